// File: doc/BRIEF.md
# Packed Pixel Word Unpacker

The unpacker sits between a frame-buffer word stream and a pixel pipeline. Each accepted 32-bit word is split into pixels, and one pixel leaves per cycle on a valid/ready output. The count of pixels per word depends on the colour depth: 32, 16, 8, 4, 2 or 1. Indexed depths (1, 2, 4 and 8 bits) produce a palette index and raise an indexed flag. Direct depths produce a 24-bit colour. These are the 16-bit layouts 565, 555 (top bit ignored) and 444, and a 24-bit colour held in a 32-bit container.

The byte and pixel ordering, the 16-bit sub-format and a red/blue swap are static configuration. A small two-state controller governs the flow. `ST_IDLE` holds no word and waits. Transition *load* (`in_valid` in `ST_IDLE`) captures the word into `ST_EMIT`. In `ST_EMIT`, transition *advance* shifts to the next pixel on each output handshake. On the final pixel there are two exits. Transition *reload* takes the next word in the same cycle when one is offered. Transition *drain* returns to `ST_IDLE` when none is offered.

Top module: `pix_unpack`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `out_valid` low and `in_ready` high, and it discards any partly emitted word. The first pixel after reset comes from the next accepted word.
- R2: `cfg_depth` 0,1,2,3,4,5 gives 32,16,8,4,2,1 pixels per word, and values 6 and 7 give 1. A new word is accepted only in the cycle in which the last pixel of the held word is taken, or when no word is held.
- R3: For depths 0 to 3 (1, 2, 4, 8 bits per pixel), `out_indexed` is 1 and `out_rgb` is 0. `out_index` is the pixel value zero-extended to 8 bits. With `cfg_order` 0, pixel k of a word of width b is bits [k*b +: b].
- R4: With `cfg_order` 1, the four bytes of the word are reversed (byte 3 becomes byte 0) before pixels are taken as in order 0. This applies at every depth.
- R5: With `cfg_order` 2, bytes are taken from byte 0 upward, but sub-byte pixels (depths 0 to 2) are taken from the most significant end of each byte first. At depths 3 and above, order 2 equals order 0.
- R6: At depth 4, each word carries two pixels. After reordering, the low halfword is emitted first, and `out_indexed` and `out_index` are 0. With `cfg_sub` 0 (and 3) the layout is 565: fields [4:0], [10:5], [15:11] become {f,3'b0}, {f,2'b0}, {f,3'b0}.
- R7: With `cfg_sub` 1, the layout is 555. Fields [4:0], [9:5], [14:10] are each expanded as {f,3'b0}, and bit 15 of the halfword has no effect.
- R8: With `cfg_sub` 2, the layout is 444. Fields [3:0], [7:4], [11:8] are each expanded as {f,4'b0}, and bits [15:12] have no effect.
- R9: At depths 5 to 7, bytes 0, 1 and 2 of the reordered word are the low field, green and the high field, and byte 3 has no effect.
- R10: `out_rgb` is {red, green, blue} with red in [23:16]. With `cfg_swap` 0 the low field is blue and the high field is red. With `cfg_swap` 1 the low field is red.
- R11: While `out_valid` is high and `out_ready` low, the pixel outputs stay unchanged and no pixel is skipped.
- R12: Depth, sub-format, order and swap are sampled when a word is accepted. Changing them while that word is being emitted does not change its pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_depth | input | 3 | Colour depth code |
| cfg_sub | input | 2 | 16-bit sub-format code |
| cfg_order | input | 2 | Byte/pixel ordering code |
| cfg_swap | input | 1 | Red/blue swap |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word accepted this cycle when valid |
| in_word | input | 32 | Packed frame-buffer word |
| out_valid | output | 1 | Pixel present |
| out_ready | input | 1 | Pixel taken this cycle when valid |
| out_indexed | output | 1 | Pixel is a palette index |
| out_index | output | 8 | Palette index |
| out_rgb | output | 24 | Direct colour {R,G,B} |

## Verification
The hardest situations to reach are those where two words meet at a boundary. One is the reload in the very cycle the last pixel is taken. Another is a reset that lands partway through a 32-pixel word. A third is a configuration change while a word is still draining. The stimulus holds `in_valid` high across a word boundary and checks `in_ready` on each cycle. It asserts reset after three of 32 pixels and then sends a single-pixel word. It also rewrites the depth and order the cycle after acceptance and expects the old layout to persist.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;
    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = WORD_W / BYTE_W;
    localparam int IDX_W   = 8;
    localparam int COMP_W  = 8;
    localparam int RGB_W   = 3 * COMP_W;
    localparam int CNT_W   = $clog2(WORD_W);
    localparam int PPW_W   = CNT_W + 1;
    localparam int DEPTH_W = 3;
    localparam int SUB_W   = 2;
    localparam int ORD_W   = 2;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } state_t;

    typedef struct packed {
        logic [DEPTH_W-1:0] depth;
        logic [SUB_W-1:0]   sub;
        logic               swap;
    } mode_t;

    // pixels carried by one word at a given depth code
    function automatic logic [PPW_W-1:0] ppw_of(input logic [DEPTH_W-1:0] d);
        case (d)
            3'd0:    ppw_of = PPW_W'(32);
            3'd1:    ppw_of = PPW_W'(16);
            3'd2:    ppw_of = PPW_W'(8);
            3'd3:    ppw_of = PPW_W'(4);
            3'd4:    ppw_of = PPW_W'(2);
            default: ppw_of = PPW_W'(1);
        endcase
    endfunction

    // bits consumed per pixel
    function automatic logic [PPW_W-1:0] step_of(input logic [DEPTH_W-1:0] d);
        case (d)
            3'd0:    step_of = PPW_W'(1);
            3'd1:    step_of = PPW_W'(2);
            3'd2:    step_of = PPW_W'(4);
            3'd3:    step_of = PPW_W'(8);
            3'd4:    step_of = PPW_W'(16);
            default: step_of = PPW_W'(32);
        endcase
    endfunction
endpackage

// File: rtl/pix_word_reorder.sv
module pix_word_reorder
    import pix_unpack_pkg::*;
(
    input  logic [WORD_W-1:0]  word_i,
    input  logic [ORD_W-1:0]   order_i,
    input  logic [DEPTH_W-1:0] depth_i,
    output logic [WORD_W-1:0]  word_o
);
    logic [WORD_W-1:0] byte_rev;
    logic [WORD_W-1:0] group_rev;

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        logic [BYTE_W-1:0] src;
        logic [BYTE_W-1:0] rev1;
        logic [BYTE_W-1:0] rev2;
        logic [BYTE_W-1:0] rev4;

        assign src = word_i[i*BYTE_W +: BYTE_W];
        assign byte_rev[i*BYTE_W +: BYTE_W] = word_i[(NBYTES-1-i)*BYTE_W +: BYTE_W];

        for (genvar j = 0; j < BYTE_W; j++) begin : g_bit
            assign rev1[j] = src[BYTE_W-1-j];
        end
        for (genvar j = 0; j < BYTE_W/2; j++) begin : g_pair
            assign rev2[2*j +: 2] = src[(BYTE_W/2-1-j)*2 +: 2];
        end
        assign rev4 = {src[3:0], src[7:4]};

        always_comb begin
            case (depth_i)
                3'd0:    group_rev[i*BYTE_W +: BYTE_W] = rev1;
                3'd1:    group_rev[i*BYTE_W +: BYTE_W] = rev2;
                3'd2:    group_rev[i*BYTE_W +: BYTE_W] = rev4;
                default: group_rev[i*BYTE_W +: BYTE_W] = src;
            endcase
        end
    end

    always_comb begin
        case (order_i)
            2'd1:    word_o = byte_rev;
            2'd2:    word_o = group_rev;
            default: word_o = word_i;
        endcase
    end
endmodule

// File: rtl/pix_unpack_fsm.sv
module pix_unpack_fsm
    import pix_unpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] word_i,
    input  mode_t             mode_i,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] shr_o,
    output mode_t             mode_o
);
    state_t            state_q;
    state_t            state_d;
    logic [CNT_W-1:0]  pix_cnt;
    logic [WORD_W-1:0] shr_q;
    mode_t             mode_q;
    logic              last;
    logic              take;
    logic              load;

    assign last = ({1'b0, pix_cnt} == (ppw_of(mode_q.depth) - PPW_W'(1)));
    assign take = out_valid && out_ready;
    assign load = in_valid && in_ready;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // transitions: load, advance, reload, drain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_EMIT;
            ST_EMIT: if (take && last && !in_valid) state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        in_ready  = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready = 1'b1;
            ST_EMIT: begin
                out_valid = 1'b1;
                in_ready  = out_ready && last;
            end
        endcase
    end

    // word shifter and pixel counter
    always_ff @(posedge clk) begin
        if (rst) begin
            shr_q   <= '0;
            pix_cnt <= '0;
            mode_q  <= '0;
        end else if (load) begin
            shr_q   <= word_i;
            pix_cnt <= '0;
            mode_q  <= mode_i;
        end else if (take) begin
            shr_q   <= shr_q >> step_of(mode_q.depth);
            pix_cnt <= pix_cnt + CNT_W'(1);
        end
    end

    assign shr_o  = shr_q;
    assign mode_o = mode_q;
endmodule

// File: rtl/pix_color_expand.sv
module pix_color_expand
    import pix_unpack_pkg::*;
(
    input  logic [RGB_W-1:0] px_i,
    input  mode_t            mode_i,
    output logic             indexed_o,
    output logic [IDX_W-1:0] index_o,
    output logic [RGB_W-1:0] rgb_o
);
    logic [COMP_W-1:0] lo_c;
    logic [COMP_W-1:0] mid_c;
    logic [COMP_W-1:0] hi_c;
    logic              direct;

    always_comb begin
        indexed_o = 1'b1;
        index_o   = '0;
        direct    = 1'b0;
        lo_c      = '0;
        mid_c     = '0;
        hi_c      = '0;
        case (mode_i.depth)
            3'd0: index_o = {7'd0, px_i[0]};
            3'd1: index_o = {6'd0, px_i[1:0]};
            3'd2: index_o = {4'd0, px_i[3:0]};
            3'd3: index_o = px_i[7:0];
            3'd4: begin
                indexed_o = 1'b0;
                direct    = 1'b1;
                case (mode_i.sub)
                    2'd1: begin
                        lo_c  = {px_i[4:0],   3'b0};
                        mid_c = {px_i[9:5],   3'b0};
                        hi_c  = {px_i[14:10], 3'b0};
                    end
                    2'd2: begin
                        lo_c  = {px_i[3:0],  4'b0};
                        mid_c = {px_i[7:4],  4'b0};
                        hi_c  = {px_i[11:8], 4'b0};
                    end
                    default: begin
                        lo_c  = {px_i[4:0],   3'b0};
                        mid_c = {px_i[10:5],  2'b0};
                        hi_c  = {px_i[15:11], 3'b0};
                    end
                endcase
            end
            default: begin
                indexed_o = 1'b0;
                direct    = 1'b1;
                lo_c      = px_i[7:0];
                mid_c     = px_i[15:8];
                hi_c      = px_i[23:16];
            end
        endcase
        if (!direct)          rgb_o = '0;
        else if (mode_i.swap) rgb_o = {lo_c, mid_c, hi_c};
        else                  rgb_o = {hi_c, mid_c, lo_c};
    end
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
    import pix_unpack_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [DEPTH_W-1:0] cfg_depth,
    input  logic [SUB_W-1:0]   cfg_sub,
    input  logic [ORD_W-1:0]   cfg_order,
    input  logic               cfg_swap,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WORD_W-1:0]  in_word,
    output logic               out_valid,
    input  logic               out_ready,
    output logic               out_indexed,
    output logic [IDX_W-1:0]   out_index,
    output logic [RGB_W-1:0]   out_rgb
);
    logic [WORD_W-1:0] word_ord;
    logic [WORD_W-1:0] shr;
    mode_t             mode_in;
    mode_t             mode_cur;

    assign mode_in = '{depth: cfg_depth, sub: cfg_sub, swap: cfg_swap};

    pix_word_reorder u_reorder (
        .word_i  (in_word),
        .order_i (cfg_order),
        .depth_i (cfg_depth),
        .word_o  (word_ord)
    );

    pix_unpack_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .word_i    (word_ord),
        .mode_i    (mode_in),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .shr_o     (shr),
        .mode_o    (mode_cur)
    );

    pix_color_expand u_expand (
        .px_i      (shr[RGB_W-1:0]),
        .mode_i    (mode_cur),
        .indexed_o (out_indexed),
        .index_o   (out_index),
        .rgb_o     (out_rgb)
    );

    logic unused_top;
    assign unused_top = ^shr[WORD_W-1:RGB_W];
endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk
    import pix_unpack_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [DEPTH_W-1:0] cfg_depth,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic               out_indexed,
    input logic [IDX_W-1:0]   out_index,
    input logic [RGB_W-1:0]   out_rgb
);
    logic [PPW_W:0]     seen_cnt;
    logic [DEPTH_W-1:0] lat_depth;
    logic               armed;
    logic               take;

    assign take = out_valid && out_ready;

    // R2: pixels between two accepted words match the depth of the earlier one
    always_ff @(posedge clk) begin
        if (rst) begin
            seen_cnt  <= '0;
            lat_depth <= '0;
            armed     <= 1'b0;
        end else if (in_valid && in_ready) begin
            if (armed) begin
                a_r2_pixel_count: assert ((seen_cnt + (PPW_W+1)'(take)) == (PPW_W+1)'(ppw_of(lat_depth)))
                    else $error("pixel count per word differs from depth");
            end
            seen_cnt  <= '0;
            lat_depth <= cfg_depth;
            armed     <= 1'b1;
        end else if (take) begin
            seen_cnt <= seen_cnt + (PPW_W+1)'(1);
        end
    end

    a_r2_no_early_accept: assert property (@(posedge clk) disable iff (rst)
        (out_valid && in_ready) |-> out_ready);

    a_r11_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_index)
                                       && $stable(out_rgb) && $stable(out_indexed)));

    a_r3_index_no_colour: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_indexed) |-> (out_rgb == '0));

    a_r6_colour_no_index: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_indexed) |-> (out_index == '0));
endmodule

bind pix_unpack pix_unpack_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_depth   (cfg_depth),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_indexed (out_indexed),
    .out_index   (out_index),
    .out_rgb     (out_rgb)
);

// File: tb/pix_unpack_test.sv
module pix_unpack_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_depth = '0;
    logic [1:0]  cfg_sub = '0;
    logic [1:0]  cfg_order = '0;
    logic        cfg_swap = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        out_indexed;
    logic [7:0]  out_index;
    logic [23:0] out_rgb;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    pix_unpack uut (
        .clk(clk), .rst(rst), .cfg_depth(cfg_depth), .cfg_sub(cfg_sub),
        .cfg_order(cfg_order), .cfg_swap(cfg_swap), .in_valid(in_valid),
        .in_ready(in_ready), .in_word(in_word), .out_valid(out_valid),
        .out_ready(out_ready), .out_indexed(out_indexed), .out_index(out_index),
        .out_rgb(out_rgb)
    );

    function automatic int ppw_b(input logic [2:0] d);
        if (d <= 3'd4) return 32 >> d;
        return 1;
    endfunction

    function automatic logic [32:0] exp_px(input logic [31:0] w, input logic [2:0] d,
                                           input logic [1:0] s, input logic [1:0] o,
                                           input logic sw, input int k);
        logic [31:0] ww;
        logic [15:0] hw;
        logic [7:0]  lo, mi, hi, v;
        int b, ppb, off;
        ww = (o == 2'd1) ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
        if (d <= 3'd3) begin
            b   = 1 << d;
            ppb = 8 / b;
            if (o == 2'd2 && d < 3'd3) off = (k / ppb) * 8 + 8 - b * ((k % ppb) + 1);
            else                       off = k * b;
            v = 8'((ww >> off) & ((32'd1 << b) - 32'd1));
            return {1'b1, v, 24'h0};
        end
        if (d == 3'd4) begin
            hw = (k == 0) ? ww[15:0] : ww[31:16];
            case (s)
                2'd1: begin lo = {hw[4:0], 3'b0}; mi = {hw[9:5], 3'b0}; hi = {hw[14:10], 3'b0}; end
                2'd2: begin lo = {hw[3:0], 4'b0}; mi = {hw[7:4], 4'b0}; hi = {hw[11:8], 4'b0}; end
                default: begin lo = {hw[4:0], 3'b0}; mi = {hw[10:5], 2'b0}; hi = {hw[15:11], 3'b0}; end
            endcase
        end else begin
            lo = ww[7:0]; mi = ww[15:8]; hi = ww[23:16];
        end
        return {1'b0, 8'h0, sw ? {lo, mi, hi} : {hi, mi, lo}};
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic check_px(input string req, input logic [32:0] exp, input int k);
        logic [32:0] act;
        act = {out_indexed, out_index, out_rgb};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pixel %0d: actual=%h expected=%h", req, k, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [2:0] d, input logic [1:0] s,
                           input logic [1:0] o, input logic sw);
        @(negedge clk);
        cfg_depth = d; cfg_sub = s; cfg_order = o; cfg_swap = sw;
    endtask

    // offer one word, drain it with out_ready held high, expect out_valid low afterwards
    task automatic push_and_drain(input string req, input logic [31:0] w);
        int n;
        n = ppw_b(cfg_depth);
        @(negedge clk);
        in_word = w; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            check_bit(req, out_valid, 1'b1, "out_valid during word");
            check_px(req, exp_px(w, cfg_depth, cfg_sub, cfg_order, cfg_swap, k), k);
            @(negedge clk);
        end
        check_bit(req, out_valid, 1'b0, "out_valid after word");
    endtask

    task automatic t_reset();
        check_bit("R1", out_valid, 1'b0, "out_valid in reset");
        check_bit("R1", in_ready, 1'b1, "in_ready in reset");
        @(negedge clk); rst = 1'b0;
        check_bit("R1", out_valid, 1'b0, "out_valid after reset");
    endtask

    task automatic t_indexed_order0();
        set_cfg(3'd0, 2'd0, 2'd0, 1'b0); push_and_drain("R3", 32'hA5C3_0F96);
        set_cfg(3'd1, 2'd0, 2'd0, 1'b0); push_and_drain("R3", 32'h1B2E_D487);
        set_cfg(3'd2, 2'd0, 2'd0, 1'b0); push_and_drain("R3", 32'hFEDC_BA98);
        set_cfg(3'd3, 2'd0, 2'd0, 1'b0); push_and_drain("R3", 32'h80FF_017E);
    endtask

    task automatic t_order_bytes();
        set_cfg(3'd0, 2'd0, 2'd1, 1'b0); push_and_drain("R4", 32'h0001_8043);
        set_cfg(3'd2, 2'd0, 2'd1, 1'b0); push_and_drain("R4", 32'h1234_5678);
        set_cfg(3'd3, 2'd0, 2'd1, 1'b0); push_and_drain("R4", 32'hAABB_CCDD);
        set_cfg(3'd4, 2'd0, 2'd1, 1'b0); push_and_drain("R4", 32'hF800_07E0);
    endtask

    task automatic t_order_subbyte();
        set_cfg(3'd0, 2'd0, 2'd2, 1'b0); push_and_drain("R5", 32'h0180_C3A5);
        set_cfg(3'd1, 2'd0, 2'd2, 1'b0); push_and_drain("R5", 32'h1B2E_D487);
        set_cfg(3'd2, 2'd0, 2'd2, 1'b0); push_and_drain("R5", 32'h1234_5678);
        set_cfg(3'd3, 2'd0, 2'd2, 1'b0); push_and_drain("R5", 32'h4433_2211);
        set_cfg(3'd4, 2'd1, 2'd2, 1'b1); push_and_drain("R5", 32'h7C1F_83E0);
    endtask

    task automatic t_sixteen();
        set_cfg(3'd4, 2'd0, 2'd0, 1'b0); push_and_drain("R6", 32'hF81F_07E0);
        set_cfg(3'd4, 2'd3, 2'd0, 1'b0); push_and_drain("R6", 32'h8410_FFFF);
        set_cfg(3'd4, 2'd1, 2'd0, 1'b0); push_and_drain("R7", 32'hFC21_83E0);
        set_cfg(3'd4, 2'd2, 2'd0, 1'b0); push_and_drain("R8", 32'hF123_A456);
    endtask

    task automatic t_container();
        set_cfg(3'd5, 2'd0, 2'd0, 1'b0); push_and_drain("R9", 32'hEE12_3456);
        set_cfg(3'd5, 2'd0, 2'd1, 1'b1); push_and_drain("R9", 32'h11AB_CDEF);
        set_cfg(3'd7, 2'd0, 2'd0, 1'b0); push_and_drain("R9", 32'h0099_8877);
    endtask

    task automatic t_swap();
        set_cfg(3'd4, 2'd0, 2'd0, 1'b1); push_and_drain("R10", 32'hF81F_07E0);
        set_cfg(3'd5, 2'd0, 2'd0, 1'b1); push_and_drain("R10", 32'h00FF_0001);
    endtask

    task automatic t_back_to_back();
        logic [31:0] wa, wb;
        wa = 32'h1234_F800; wb = 32'h07E0_001F;
        set_cfg(3'd4, 2'd0, 2'd0, 1'b0);
        @(negedge clk); in_word = wa; in_valid = 1'b1;
        @(negedge clk); in_word = wb;
        check_px("R2", exp_px(wa, 3'd4, 2'd0, 2'd0, 1'b0, 0), 0);
        check_bit("R2", in_ready, 1'b0, "in_ready before last pixel");
        @(negedge clk);
        check_px("R2", exp_px(wa, 3'd4, 2'd0, 2'd0, 1'b0, 1), 1);
        check_bit("R2", in_ready, 1'b1, "in_ready on last pixel");
        @(negedge clk); in_valid = 1'b0;
        check_bit("R2", out_valid, 1'b1, "no gap at word boundary");
        check_px("R2", exp_px(wb, 3'd4, 2'd0, 2'd0, 1'b0, 0), 0);
        @(negedge clk);
        check_px("R2", exp_px(wb, 3'd4, 2'd0, 2'd0, 1'b0, 1), 1);
        @(negedge clk);
        check_bit("R2", out_valid, 1'b0, "idle after second word");
    endtask

    task automatic t_stall();
        logic [31:0] w;
        w = 32'h4433_2211;
        set_cfg(3'd3, 2'd0, 2'd0, 1'b0);
        @(negedge clk); in_word = w; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            out_ready = 1'b0;
            check_px("R11", exp_px(w, 3'd3, 2'd0, 2'd0, 1'b0, k), k);
            @(negedge clk);
            check_bit("R11", out_valid, 1'b1, "valid held in stall");
            check_px("R11", exp_px(w, 3'd3, 2'd0, 2'd0, 1'b0, k), k);
            out_ready = 1'b1;
            @(negedge clk);
        end
        check_bit("R11", out_valid, 1'b0, "idle after stalled word");
    endtask

    task automatic t_cfg_change();
        logic [31:0] w;
        w = 32'hC3A5_0F96;
        set_cfg(3'd3, 2'd0, 2'd1, 1'b0);
        @(negedge clk); in_word = w; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        cfg_depth = 3'd0; cfg_order = 2'd0;
        for (int k = 0; k < 4; k++) begin
            check_px("R12", exp_px(w, 3'd3, 2'd0, 2'd1, 1'b0, k), k);
            @(negedge clk);
        end
        check_bit("R12", out_valid, 1'b0, "word length kept old depth");
    endtask

    task automatic t_reset_mid_word();
        set_cfg(3'd0, 2'd0, 2'd0, 1'b0);
        @(negedge clk); in_word = 32'hFFFF_FFFF; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_bit("R1", out_valid, 1'b0, "out_valid after mid-word reset");
        check_bit("R1", in_ready, 1'b1, "in_ready after mid-word reset");
        rst = 1'b0;
        cfg_depth = 3'd5;
        push_and_drain("R1", 32'h0012_3456);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_indexed_order0();
        t_order_bytes();
        t_order_subbyte();
        t_sixteen();
        t_container();
        t_swap();
        t_back_to_back();
        t_stall();
        t_cfg_change();
        t_reset_mid_word();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule